// File: doc/BRIEF.md
# Sync-First Raster Timing Generator

This block produces horizontal sync, vertical sync and data-enable for a video raster whose line and frame origin has been rotated: each line starts at the blanking edge, so the sync pulse comes first and the active pixels fill the tail of the line up to its last count. A programmable set of positions describes the raster. These are the line length, the frame height, the horizontal sync window, the data-enable pixel window, and, for each of two fields, a vertical sync window given as a (line, pixel) start and end plus a vertical active-line window.

In progressive operation only the first field's settings are used. In interlaced operation the second field's sync window and active-line window also apply, and a field flag marks the lower half of the frame. The second field's vertical sync normally starts half a line later than the first. A start position of zero disables its output. The whole setting is captured into a shadow copy only when a frame wraps, so a change applied mid-frame never produces a partial frame. Pixel and line counters come out with the syncs, and every output is registered and aligned to the same cycle.

Top module: `raster_sync_gen`

## Requirements
- R1: While rst_ni is low, hs_o, vs_o, de_o, field_o, pix_o and line_o are all 0.
- R2: pix_o counts 0 up to htotal-1 and then returns to 0; line_o advances by one whenever pix_o returns to 0 and itself returns to 0 after vtotal-1.
- R3: hs_o is high exactly when hs_on is nonzero and hs_on <= pix_o < hs_off.
- R4: de_o is high exactly when de_on is nonzero, de_on <= pix_o < de_off, and line_o lies in [vw_on, vw_off) of the current field (index 0 when field_o is 0, index 1 when it is 1), with that vw_on nonzero.
- R5: For field index 0, vs_o is high from position (vs_ln_on, vs_px_on) up to but not including (vs_ln_off, vs_px_off), positions ordered by line first and pixel second.
- R6: With interlace set, vs_o is also high over the index-1 window defined the same way; with interlace clear, every index-1 setting has no effect on vs_o or de_o.
- R7: field_o is 1 exactly when interlace is set and line_o >= vtotal/2 (integer division); it is always 0 in progressive operation.
- R8: Input settings are sampled only on the cycle the counters return to (line 0, pixel 0) at the end of a frame, or when the held line or frame length is zero (as after reset); changes at any other time have no effect until that point.
- R9: A zero start value (hs_on, de_on, vs_ln_on, vw_on) keeps the corresponding output low for the whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| interlace_i | input | 1 | 1 selects two-field interlaced operation |
| htotal_i | input | CW | Pixels per line |
| vtotal_i | input | CW | Lines per frame |
| hs_on_i | input | CW | First pixel of horizontal sync (0 disables) |
| hs_off_i | input | CW | First pixel after horizontal sync |
| de_on_i | input | CW | First active pixel (0 disables) |
| de_off_i | input | CW | First pixel after the active region |
| vs_ln_on_i | input | 2 x CW | Vertical sync start line per field (0 disables) |
| vs_px_on_i | input | 2 x CW | Vertical sync start pixel per field |
| vs_ln_off_i | input | 2 x CW | Vertical sync end line per field |
| vs_px_off_i | input | 2 x CW | Vertical sync end pixel per field |
| vw_on_i | input | 2 x CW | First active line per field (0 disables) |
| vw_off_i | input | 2 x CW | First line after the active lines per field |
| hs_o | output | 1 | Horizontal sync, active high |
| vs_o | output | 1 | Vertical sync, active high |
| de_o | output | 1 | Data enable, active high |
| field_o | output | 1 | 1 during the second field |
| pix_o | output | CW | Pixel counter |
| line_o | output | CW | Line counter |

## Verification
A slipped pixel or line counter shows on pix_o or line_o on the very next cycle. It also moves every sync edge after it, so the per-cycle comparison reports it at once. A corrupted or early-loaded shadow setting shows as a sync or enable edge at the wrong pixel within the current line, or as a line length that changes before the frame ends. Either is visible within one line. A wrong field decision only shows at the middle line of an interlaced frame, where field_o, the second vertical sync and the lower active window all diverge together.

// File: rtl/raster_pkg.sv
package raster_pkg;
  parameter int unsigned CW = 12;
  parameter int unsigned NF = 2;

  typedef logic [CW-1:0] cnt_t;

  typedef struct packed {
    logic                  ilace;
    cnt_t                  htotal;
    cnt_t                  vtotal;
    cnt_t                  hs_on;
    cnt_t                  hs_off;
    cnt_t                  de_on;
    cnt_t                  de_off;
    logic [NF-1:0][CW-1:0] vs_ln_on;
    logic [NF-1:0][CW-1:0] vs_px_on;
    logic [NF-1:0][CW-1:0] vs_ln_off;
    logic [NF-1:0][CW-1:0] vs_px_off;
    logic [NF-1:0][CW-1:0] vw_on;
    logic [NF-1:0][CW-1:0] vw_off;
  } raster_cfg_t;
endpackage

// File: rtl/raster_shadow.sv
module raster_shadow
  import raster_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  raster_cfg_t cfg_i,
  input  logic        frame_end_i,
  output raster_cfg_t cfg_q_o,
  output raster_cfg_t cfg_d_o,
  output logic        idle_o
);
  raster_cfg_t cfg_q;
  logic        load;

  // zero length means nothing usable is held yet
  assign idle_o  = (cfg_q.htotal == '0) || (cfg_q.vtotal == '0);
  assign load    = idle_o || frame_end_i;
  assign cfg_d_o = load ? cfg_i : cfg_q;
  assign cfg_q_o = cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d_o;
  end
endmodule

// File: rtl/raster_counter.sv
module raster_counter
  import raster_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idle_i,
  input  cnt_t htotal_i,
  input  cnt_t vtotal_i,
  output cnt_t px_q_o,
  output cnt_t ln_q_o,
  output cnt_t px_d_o,
  output cnt_t ln_d_o,
  output logic frame_end_o
);
  cnt_t px_q, ln_q;
  logic last_px, last_ln;

  assign last_px     = px_q >= cnt_t'(htotal_i - 1'b1);
  assign last_ln     = ln_q >= cnt_t'(vtotal_i - 1'b1);
  assign frame_end_o = !idle_i && last_px && last_ln;

  always_comb begin
    px_d_o = px_q + 1'b1;
    ln_d_o = ln_q;
    if (idle_i || frame_end_o) begin
      px_d_o = '0;
      ln_d_o = '0;
    end else if (last_px) begin
      px_d_o = '0;
      ln_d_o = ln_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      px_q <= '0;
      ln_q <= '0;
    end else begin
      px_q <= px_d_o;
      ln_q <= ln_d_o;
    end
  end

  assign px_q_o = px_q;
  assign ln_q_o = ln_q;
endmodule

// File: rtl/raster_span.sv
module raster_span
  import raster_pkg::*;
(
  input  cnt_t ln_i,
  input  cnt_t px_i,
  input  cnt_t ln_on_i,
  input  cnt_t px_on_i,
  input  cnt_t ln_off_i,
  input  cnt_t px_off_i,
  input  logic en_i,
  output logic hit_o
);
  logic past_on, before_off;

  // (line, pixel) ordered line first
  assign past_on    = (ln_i > ln_on_i)  || ((ln_i == ln_on_i)  && (px_i >= px_on_i));
  assign before_off = (ln_i < ln_off_i) || ((ln_i == ln_off_i) && (px_i <  px_off_i));
  assign hit_o      = en_i && (ln_on_i != '0) && past_on && before_off;
endmodule

// File: rtl/raster_decode.sv
module raster_decode
  import raster_pkg::*;
(
  input  raster_cfg_t cfg_i,
  input  cnt_t        px_i,
  input  cnt_t        ln_i,
  output logic        hs_o,
  output logic        vs_o,
  output logic        de_o,
  output logic        field_o
);
  logic [NF-1:0] vs_hit;
  logic          h_act, v_act;
  cnt_t          win_on, win_off;

  assign field_o = cfg_i.ilace && (ln_i >= (cfg_i.vtotal >> 1));

  assign hs_o = (cfg_i.hs_on != '0) && (px_i >= cfg_i.hs_on) && (px_i < cfg_i.hs_off);

  for (genvar f = 0; f < NF; f++) begin : g_vs
    logic en;
    assign en = (f == 0) ? 1'b1 : cfg_i.ilace;
    raster_span u_span (
      .ln_i     (ln_i),
      .px_i     (px_i),
      .ln_on_i  (cfg_i.vs_ln_on[f]),
      .px_on_i  (cfg_i.vs_px_on[f]),
      .ln_off_i (cfg_i.vs_ln_off[f]),
      .px_off_i (cfg_i.vs_px_off[f]),
      .en_i     (en),
      .hit_o    (vs_hit[f])
    );
  end
  assign vs_o = |vs_hit;

  assign win_on  = cfg_i.vw_on[field_o];
  assign win_off = cfg_i.vw_off[field_o];
  assign h_act   = (cfg_i.de_on != '0) && (px_i >= cfg_i.de_on) && (px_i < cfg_i.de_off);
  assign v_act   = (win_on != '0) && (ln_i >= win_on) && (ln_i < win_off);
  assign de_o    = h_act && v_act;
endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen
  import raster_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  interlace_i,
  input  logic [CW-1:0]         htotal_i,
  input  logic [CW-1:0]         vtotal_i,
  input  logic [CW-1:0]         hs_on_i,
  input  logic [CW-1:0]         hs_off_i,
  input  logic [CW-1:0]         de_on_i,
  input  logic [CW-1:0]         de_off_i,
  input  logic [NF-1:0][CW-1:0] vs_ln_on_i,
  input  logic [NF-1:0][CW-1:0] vs_px_on_i,
  input  logic [NF-1:0][CW-1:0] vs_ln_off_i,
  input  logic [NF-1:0][CW-1:0] vs_px_off_i,
  input  logic [NF-1:0][CW-1:0] vw_on_i,
  input  logic [NF-1:0][CW-1:0] vw_off_i,
  output logic                  hs_o,
  output logic                  vs_o,
  output logic                  de_o,
  output logic                  field_o,
  output logic [CW-1:0]         pix_o,
  output logic [CW-1:0]         line_o
);
  raster_cfg_t cfg_in, cfg_q, cfg_d;
  logic        idle, frame_end;
  cnt_t        px_q, ln_q, px_d, ln_d;
  logic        hs_d, vs_d, de_d, field_d;

  always_comb begin
    cfg_in.ilace     = interlace_i;
    cfg_in.htotal    = htotal_i;
    cfg_in.vtotal    = vtotal_i;
    cfg_in.hs_on     = hs_on_i;
    cfg_in.hs_off    = hs_off_i;
    cfg_in.de_on     = de_on_i;
    cfg_in.de_off    = de_off_i;
    cfg_in.vs_ln_on  = vs_ln_on_i;
    cfg_in.vs_px_on  = vs_px_on_i;
    cfg_in.vs_ln_off = vs_ln_off_i;
    cfg_in.vs_px_off = vs_px_off_i;
    cfg_in.vw_on     = vw_on_i;
    cfg_in.vw_off    = vw_off_i;
  end

  raster_shadow u_shadow (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_i       (cfg_in),
    .frame_end_i (frame_end),
    .cfg_q_o     (cfg_q),
    .cfg_d_o     (cfg_d),
    .idle_o      (idle)
  );

  raster_counter u_count (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idle_i      (idle),
    .htotal_i    (cfg_q.htotal),
    .vtotal_i    (cfg_q.vtotal),
    .px_q_o      (px_q),
    .ln_q_o      (ln_q),
    .px_d_o      (px_d),
    .ln_d_o      (ln_d),
    .frame_end_o (frame_end)
  );

  // decode next-state position with next-state settings so flags line up with counters
  raster_decode u_dec (
    .cfg_i   (cfg_d),
    .px_i    (px_d),
    .ln_i    (ln_d),
    .hs_o    (hs_d),
    .vs_o    (vs_d),
    .de_o    (de_d),
    .field_o (field_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_o    <= 1'b0;
      vs_o    <= 1'b0;
      de_o    <= 1'b0;
      field_o <= 1'b0;
    end else begin
      hs_o    <= hs_d;
      vs_o    <= vs_d;
      de_o    <= de_d;
      field_o <= field_d;
    end
  end

  assign pix_o  = px_q;
  assign line_o = ln_q;
endmodule

// File: rtl/raster_sync_gen_chk.sv
module raster_sync_gen_chk
  import raster_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        hs_o,
  input logic        de_o,
  input logic        field_o,
  input cnt_t        pix_o,
  input cnt_t        line_o,
  input raster_cfg_t cfg_q
);
  // R2
  pix_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_o != '0) |-> (pix_o == cnt_t'($past(pix_o) + 1'b1)));

  // R2
  line_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_o != $past(line_o)) |-> (pix_o == '0));

  // R3
  hs_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_o |-> (pix_o != '0));

  // R4
  de_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (pix_o != '0));

  // R7
  field_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(field_o) |-> (pix_o == '0));

  // R7
  field_prog_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q.ilace |-> !field_o);

  // R8
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_q) |-> ((pix_o == '0) && (line_o == '0)));
endmodule

bind raster_sync_gen raster_sync_gen_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .hs_o    (hs_o),
  .de_o    (de_o),
  .field_o (field_o),
  .pix_o   (pix_o),
  .line_o  (line_o),
  .cfg_q   (cfg_q)
);

// File: tb/sim_raster_sync_gen.sv
`timescale 1ns/1ps
module sim_raster_sync_gen;
  import raster_pkg::*;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  raster_cfg_t drv = '0;
  logic hs, vs, de, fld;
  cnt_t pix, lin;

  raster_sync_gen u0 (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .interlace_i (drv.ilace),
    .htotal_i    (drv.htotal),
    .vtotal_i    (drv.vtotal),
    .hs_on_i     (drv.hs_on),
    .hs_off_i    (drv.hs_off),
    .de_on_i     (drv.de_on),
    .de_off_i    (drv.de_off),
    .vs_ln_on_i  (drv.vs_ln_on),
    .vs_px_on_i  (drv.vs_px_on),
    .vs_ln_off_i (drv.vs_ln_off),
    .vs_px_off_i (drv.vs_px_off),
    .vw_on_i     (drv.vw_on),
    .vw_off_i    (drv.vw_off),
    .hs_o        (hs),
    .vs_o        (vs),
    .de_o        (de),
    .field_o     (fld),
    .pix_o       (pix),
    .line_o      (lin)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0, cmp_on = 0;

  task automatic check(string rq, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", rq, what, act, exp, $time);
    end
  endtask

  // behavioural reference
  raster_cfg_t m_cfg = '0;
  int m_px = 0, m_ln = 0;

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_cfg = '0; m_px = 0; m_ln = 0;
    end else if (m_cfg.htotal == 0 || m_cfg.vtotal == 0) begin
      m_cfg = drv; m_px = 0; m_ln = 0;
    end else if (m_px == int'(m_cfg.htotal) - 1) begin
      m_px = 0;
      if (m_ln == int'(m_cfg.vtotal) - 1) begin
        m_ln = 0; m_cfg = drv;
      end else m_ln++;
    end else m_px++;
  end

  function automatic bit m_field();
    return m_cfg.ilace && (m_ln >= int'(m_cfg.vtotal) / 2);
  endfunction

  function automatic bit m_vs_win(int f);
    int lon = int'(m_cfg.vs_ln_on[f]), pon = int'(m_cfg.vs_px_on[f]);
    int lof = int'(m_cfg.vs_ln_off[f]), pof = int'(m_cfg.vs_px_off[f]);
    if (lon == 0) return 0;
    if (f == 1 && !m_cfg.ilace) return 0;
    return (m_ln > lon || (m_ln == lon && m_px >= pon)) &&
           (m_ln < lof || (m_ln == lof && m_px < pof));
  endfunction

  function automatic bit m_de();
    int f = m_field();
    int won = int'(m_cfg.vw_on[f]), wof = int'(m_cfg.vw_off[f]);
    if (m_cfg.de_on == 0 || won == 0) return 0;
    return m_px >= int'(m_cfg.de_on) && m_px < int'(m_cfg.de_off) &&
           m_ln >= won && m_ln < wof;
  endfunction

  always @(negedge clk) begin
    if (!rst_ni) begin
      check("R1", "hs in reset", int'(hs), 0);
      check("R1", "vs in reset", int'(vs), 0);
      check("R1", "de in reset", int'(de), 0);
      check("R1", "field in reset", int'(fld), 0);
      check("R1", "pix in reset", int'(pix), 0);
      check("R1", "line in reset", int'(lin), 0);
    end else if (cmp_on) begin
      check("R2", "pix", int'(pix), m_px);
      check("R2", "line", int'(lin), m_ln);
      check("R3", "hs", int'(hs), int'(m_cfg.hs_on != 0 && m_px >= int'(m_cfg.hs_on) && m_px < int'(m_cfg.hs_off)));
      check("R5", "vs", int'(vs), int'(m_vs_win(0) || m_vs_win(1)));
      check("R4", "de", int'(de), int'(m_de()));
      check("R7", "field", int'(fld), int'(m_field()));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  // always advances at least one cycle
  task automatic wait_pos(int l, int p);
    int k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!(int'(lin) == l && int'(pix) == p) && k < 3000);
    if (k >= 3000) check("R2", "position reached", 0, 1);
  endtask

  task automatic count_frame(output int n_hs, output int n_vs, output int n_de, output int n_fld);
    n_hs = 0; n_vs = 0; n_de = 0; n_fld = 0;
    wait_pos(0, 0);
    do begin
      n_hs += int'(hs); n_vs += int'(vs); n_de += int'(de); n_fld += int'(fld);
      @(negedge clk);
    end while (!(pix == '0 && lin == '0));
  endtask

  // conventional modeline -> sync-first positions
  task automatic set_mode(bit il, int ht, int hd, int hss, int hse,
                          int vt, int vd, int vss, int vse);
    raster_cfg_t c = '0;
    int hs0 = hss - hd;
    c.ilace = il; c.htotal = cnt_t'(ht); c.vtotal = cnt_t'(vt);
    c.hs_on = cnt_t'(hs0); c.hs_off = cnt_t'(hse - hd);
    c.de_on = cnt_t'(ht - hd); c.de_off = cnt_t'(ht);
    c.vs_px_on[0] = cnt_t'(hs0); c.vs_px_off[0] = cnt_t'(hs0);
    if (!il) begin
      c.vs_ln_on[0]  = cnt_t'(vss - vd);
      c.vs_ln_off[0] = cnt_t'(vss - vd + vse - vss);
      c.vw_on[0]     = cnt_t'(vt - vd - 1);
      c.vw_off[0]    = cnt_t'(vt - 1);
    end else begin
      c.vs_ln_on[0]  = cnt_t'((vss - vd) / 2);
      c.vs_ln_off[0] = cnt_t'((vss - vd) / 2 + (vse - vss) / 2);
      c.vw_on[0]     = cnt_t'((vt - vd) / 2);
      c.vw_off[0]    = cnt_t'((vt - vd) / 2 + vd / 2);
      c.vs_px_on[1]  = cnt_t'(hs0 + ht / 2);
      c.vs_px_off[1] = cnt_t'(hs0 + ht / 2);
      c.vs_ln_on[1]  = cnt_t'((vss - vd) / 2 + vt / 2);
      c.vs_ln_off[1] = cnt_t'((vss - vd) / 2 + vt / 2 + (vse - vss) / 2);
      c.vw_on[1]     = cnt_t'((vt - vd) / 2 + vt / 2);
      c.vw_off[1]    = cnt_t'((vt - vd) / 2 + vt / 2 + vd / 2);
    end
    drv = c;
  endtask

  initial begin
    int a, b, c, d;
    // A: ht20 hs 2..4 de 8..20; vt10 vs lines 1..2 @px2, window 3..9
    set_mode(0, 20, 12, 14, 16, 10, 6, 7, 8);
    // R6: field-1 settings present but progressive must ignore them
    drv.vs_ln_on[1] = 6; drv.vs_px_on[1] = 5; drv.vs_ln_off[1] = 7; drv.vs_px_off[1] = 5;
    drv.vw_on[1] = 1; drv.vw_off[1] = 3;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    cmp_on = 1;

    count_frame(a, b, c, d);
    check("R3", "hs cycles per frame A", a, 20);
    check("R5", "vs cycles per frame A", b, 20);
    check("R4", "de cycles per frame A", c, 72);
    check("R7", "field cycles progressive", d, 0);

    wait_pos(0, 1);  check("R3", "hs before on", int'(hs), 0);
    wait_pos(0, 2);  check("R3", "hs at on", int'(hs), 1);
    wait_pos(0, 4);  check("R3", "hs at off", int'(hs), 0);
    wait_pos(1, 1);  check("R5", "vs before start", int'(vs), 0);
    wait_pos(1, 2);  check("R5", "vs at start", int'(vs), 1);
    wait_pos(2, 1);  check("R5", "vs before end", int'(vs), 1);
    wait_pos(2, 2);  check("R5", "vs at end", int'(vs), 0);
    wait_pos(2, 10); check("R4", "de above window", int'(de), 0);
    wait_pos(3, 7);  check("R4", "de before on", int'(de), 0);
    wait_pos(3, 8);  check("R4", "de at on", int'(de), 1);
    wait_pos(3, 19); check("R4", "de at last pixel", int'(de), 1);
    wait_pos(6, 5);  check("R6", "field-1 vs ignored", int'(vs), 0);
    wait_pos(9, 19);
    @(negedge clk);
    check("R2", "line wrap pix", int'(pix), 0);
    check("R2", "line wrap line", int'(lin), 0);

    // R8: reprogram mid-frame to interlaced B
    wait_pos(4, 5);
    set_mode(1, 24, 16, 18, 20, 22, 12, 14, 18);
    wait_pos(4, 19);
    @(negedge clk);
    check("R8", "old length kept pix", int'(pix), 0);
    check("R8", "old length kept line", int'(lin), 5);
    wait_pos(0, 0);
    repeat (23) @(negedge clk);
    check("R8", "new length pix", int'(pix), 23);
    check("R8", "new length line", int'(lin), 0);

    count_frame(a, b, c, d);
    check("R3", "hs cycles per frame B", a, 44);
    check("R6", "vs cycles per frame B", b, 96);
    check("R4", "de cycles per frame B", c, 192);
    check("R7", "field cycles B", d, 264);

    wait_pos(10, 23); check("R7", "field before half", int'(fld), 0);
    wait_pos(11, 0);  check("R7", "field at half", int'(fld), 1);
    wait_pos(12, 13); check("R6", "vs2 before half-line start", int'(vs), 0);
    wait_pos(12, 14); check("R6", "vs2 at half-line start", int'(vs), 1);
    wait_pos(13, 0);  check("R6", "vs2 mid", int'(vs), 1);
    wait_pos(14, 14); check("R6", "vs2 at end", int'(vs), 0);
    wait_pos(16, 8);  check("R4", "de field 2 window", int'(de), 1);
    wait_pos(0, 0);   check("R7", "field back to 0", int'(fld), 0);

    // R9: zero starts disable outputs
    drv.hs_on = '0; drv.de_on = '0; drv.vs_ln_on = '0;
    wait_pos(0, 5);
    count_frame(a, b, c, d);
    check("R9", "hs disabled", a, 0);
    check("R9", "vs disabled", b, 0);
    check("R9", "de disabled", c, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule